// File: doc/BRIEF.md
# Snoop Inquire Cycle Controller

This block sits on the processor side of a shared system bus. It decides when an outside agent may probe the processor's cache. It also answers each probe with a line-present flag and a dirty-line flag. An outside agent first takes the address bus from the processor in one of two ways. It can raise the address-hold input or the backoff input. Or it can raise a hold request, which the block answers with a grant acknowledge. After that handover settles, the agent pulses the inquire strobe with an address on the inquire address bus.

An ownership state machine tracks the handover through three states. OWN_CPU means the processor owns the bus. OWN_SETTLE is the single edge after a handover. OWN_OPEN means inquiries may be sampled. The transitions are:
- seize: OWN_CPU to OWN_SETTLE, on hold, on backoff, or on a request granted while the processor is not driving the bus.
- settle: OWN_SETTLE to OWN_OPEN, while ownership is kept.
- stay: OWN_OPEN to itself, while ownership is kept.
- release: back to OWN_CPU from any state when ownership ends.

A strobe seen in OWN_OPEN is still dropped by several blackout rules. When it is accepted, its address is looked up in a direct-mapped table of tags and line states. A response state machine then holds the result. Its states are RSP_MISS, RSP_CLEAN and RSP_DIRTY. On an accepted inquire it moves to the state that matches the lookup. A writeback-done pulse takes RSP_DIRTY to RSP_CLEAN.

The table is filled through a test-load port.

Top module: `snoop_inquire_ctrl`

## Requirements
- R1: While rst is high, and on the first edge after it, grant_ack is 0 and line_hit_n and dirty_hit_n are 1. Every table entry is invalid after reset.
- R2: After addr_hold or backoff is sampled high on edge k, an inquire strobe is first accepted on edge k+2, and only while one of them stays high. A strobe on edge k or k+1 is ignored.
- R3: grant_ack rises on the edge that samples hold_req high while own_bus_drive is low. It falls on the edge that samples hold_req low. On the hold path, a strobe is first accepted two edges after the edge that raised grant_ack.
- R4: A strobe on the edge right after an accepted strobe is ignored.
- R5: A strobe on the second edge after an edge that sampled own_strobe high is ignored.
- R6: A strobe is ignored on any edge where own_bus_drive is high.
- R7: A strobe is ignored on any edge where dirty_hit_n is low.
- R8: After the accepting edge, line_hit_n is low if and only if the indexed entry is valid and its tag matches. dirty_hit_n is low if and only if that entry is also modified. Both hold their values until the next accepted inquire.
- R9: wb_done sampled high with no accepted inquire sets dirty_hit_n to 1 and leaves line_hit_n unchanged.
- R10: The table has ENTRIES direct-mapped entries. The index is address bits [8:5] and the tag is bits [31:9] (with the defaults). State codes are 0 invalid, 1 shared, 2 exclusive and 3 modified. tload_en writes the tag and state at the indexed entry.
- R11: A strobe is ignored when addr_hold, backoff and a granted hold_req are all absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_hold | input | 1 | Agent holds the address bus |
| backoff | input | 1 | Agent forces the processor off the bus |
| hold_req | input | 1 | Agent requests the bus |
| own_bus_drive | input | 1 | Processor is driving the address bus |
| own_strobe | input | 1 | Processor's own address strobe |
| inq_strobe | input | 1 | Inquire address strobe from the agent |
| inq_addr | input | ADDR_W | Inquire address |
| wb_done | input | 1 | Writeback of the dirty line finished |
| tload_en | input | 1 | Test-load write enable |
| tload_addr | input | ADDR_W | Test-load address (index and tag) |
| tload_state | input | 2 | Test-load line state code |
| grant_ack | output | 1 | Hold acknowledge |
| line_hit_n | output | 1 | Active-low line present |
| dirty_hit_n | output | 1 | Active-low line modified |

## Verification
The bench uses the default parameters: 32-bit addresses, 16 entries and 32-byte lines. With only 16 entries, a random address space of a few tags per index is enough to produce hits, misses, tag conflicts and modified hits often. Random runs of hold, backoff, request, own-strobe and bus-drive activity bring every blackout rule, and combinations of them, into the same short window. Directed sequences fix each rule on a known edge.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_state_t;

    typedef enum logic [1:0] {
        OWN_CPU    = 2'd0,
        OWN_SETTLE = 2'd1,
        OWN_OPEN   = 2'd2
    } own_state_t;

    typedef enum logic [1:0] {
        RSP_MISS  = 2'd0,
        RSP_CLEAN = 2'd1,
        RSP_DIRTY = 2'd2
    } rsp_state_t;

endpackage

// File: rtl/snp_own_fsm.sv
module snp_own_fsm
    import snp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic addr_hold,
    input  logic backoff,
    input  logic hold_req,
    input  logic own_bus_drive,
    output logic grant_ack,
    output logic window_open
);

    own_state_t st_q, st_d;
    logic       grant_q;
    logic       seize, keep;

    assign seize = addr_hold | backoff | (hold_req & ~own_bus_drive);
    assign keep  = addr_hold | backoff | (hold_req & grant_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= OWN_CPU;
            grant_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            grant_q <= hold_req & (grant_q | ~own_bus_drive);
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OWN_CPU:    st_d = seize ? OWN_SETTLE : OWN_CPU;
            OWN_SETTLE: st_d = keep  ? OWN_OPEN   : OWN_CPU;
            OWN_OPEN:   st_d = keep  ? OWN_OPEN   : OWN_CPU;
            default:    st_d = OWN_CPU;
        endcase
    end

    always_comb begin
        grant_ack   = grant_q;
        window_open = (st_q == OWN_OPEN) & keep;
    end

    // R3
    grant_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_ack && !hold_req) |=> !grant_ack);

    // R3
    grant_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_ack) |-> $past(hold_req && !own_bus_drive));

    // R2
    open_delay_chk: assert property (@(posedge clk) disable iff (rst)
        window_open |-> $past(st_q) != OWN_CPU);

endmodule

// File: rtl/snp_strobe_gate.sv
module snp_strobe_gate #(
    parameter int LAG = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic window_open,
    input  logic inq_strobe,
    input  logic own_strobe,
    input  logic own_bus_drive,
    input  logic dirty_hit_n,
    output logic accept
);

    logic           acc_q;
    logic [LAG-1:0] os_hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= 1'b0;
            os_hist <= '0;
        end else begin
            acc_q   <= accept;
            os_hist <= {os_hist[LAG-2:0], own_strobe};
        end
    end

    assign accept = window_open & inq_strobe & ~acc_q & ~os_hist[LAG-1]
                  & ~own_bus_drive & dirty_hit_n;

    // R4
    no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);

    // R5
    lag_block_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> !$past(own_strobe, 2));

    // R6
    drive_block_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> !own_bus_drive);

    // R7
    dirty_block_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> dirty_hit_n);

endmodule

// File: rtl/snp_tag_table.sv
module snp_tag_table
    import snp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int OFF_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [1:0]        load_state,
    output logic              rd_hit,
    output logic              rd_dirty
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [TAG_W-1:0] tag_q [ENTRIES];
    line_state_t      st_q  [ENTRIES];

    logic [IDX_W-1:0] rd_idx, ld_idx;
    logic [TAG_W-1:0] rd_tag, ld_tag;
    logic             offset_unused;

    assign rd_idx = rd_addr[OFF_W +: IDX_W];
    assign rd_tag = rd_addr[ADDR_W-1 -: TAG_W];
    assign ld_idx = load_addr[OFF_W +: IDX_W];
    assign ld_tag = load_addr[ADDR_W-1 -: TAG_W];
    assign offset_unused = ^{rd_addr[OFF_W-1:0], load_addr[OFF_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) st_q[i] <= LS_INV;
        end else if (load_en) begin
            st_q[ld_idx] <= line_state_t'(load_state);
        end
    end

    always_ff @(posedge clk) begin
        if (load_en) tag_q[ld_idx] <= ld_tag;
    end

    always_comb begin
        rd_hit   = (st_q[rd_idx] != LS_INV) && (tag_q[rd_idx] == rd_tag);
        rd_dirty = rd_hit && (st_q[rd_idx] == LS_MOD);
    end

endmodule

// File: rtl/snp_resp.sv
module snp_resp
    import snp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic look_hit,
    input  logic look_dirty,
    input  logic wb_done,
    output logic line_hit_n,
    output logic dirty_hit_n
);

    rsp_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= RSP_MISS;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (accept) begin
            if (look_dirty)    st_d = RSP_DIRTY;
            else if (look_hit) st_d = RSP_CLEAN;
            else               st_d = RSP_MISS;
        end else begin
            unique case (st_q)
                RSP_MISS:  st_d = RSP_MISS;
                RSP_CLEAN: st_d = RSP_CLEAN;
                RSP_DIRTY: st_d = wb_done ? RSP_CLEAN : RSP_DIRTY;
                default:   st_d = RSP_MISS;
            endcase
        end
    end

    always_comb begin
        line_hit_n  = (st_q == RSP_MISS);
        dirty_hit_n = (st_q != RSP_DIRTY);
    end

    // R8
    hitm_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !dirty_hit_n |-> !line_hit_n);

    // R9
    wb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_done && !accept) |=> (dirty_hit_n && $stable(line_hit_n)));

endmodule

// File: rtl/snoop_inquire_ctrl.sv
module snoop_inquire_ctrl #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int OFF_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_hold,
    input  logic              backoff,
    input  logic              hold_req,
    input  logic              own_bus_drive,
    input  logic              own_strobe,
    input  logic              inq_strobe,
    input  logic [ADDR_W-1:0] inq_addr,
    input  logic              wb_done,
    input  logic              tload_en,
    input  logic [ADDR_W-1:0] tload_addr,
    input  logic [1:0]        tload_state,
    output logic              grant_ack,
    output logic              line_hit_n,
    output logic              dirty_hit_n
);

    logic window_open, accept, look_hit, look_dirty;

    snp_own_fsm u_own (
        .clk(clk), .rst(rst), .addr_hold(addr_hold), .backoff(backoff),
        .hold_req(hold_req), .own_bus_drive(own_bus_drive),
        .grant_ack(grant_ack), .window_open(window_open)
    );

    snp_strobe_gate #(.LAG(2)) u_gate (
        .clk(clk), .rst(rst), .window_open(window_open),
        .inq_strobe(inq_strobe), .own_strobe(own_strobe),
        .own_bus_drive(own_bus_drive), .dirty_hit_n(dirty_hit_n),
        .accept(accept)
    );

    snp_tag_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .OFF_W(OFF_W)) u_tab (
        .clk(clk), .rst(rst), .rd_addr(inq_addr), .load_en(tload_en),
        .load_addr(tload_addr), .load_state(tload_state),
        .rd_hit(look_hit), .rd_dirty(look_dirty)
    );

    snp_resp u_resp (
        .clk(clk), .rst(rst), .accept(accept), .look_hit(look_hit),
        .look_dirty(look_dirty), .wb_done(wb_done),
        .line_hit_n(line_hit_n), .dirty_hit_n(dirty_hit_n)
    );

    // R11
    accept_needs_owner_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> (addr_hold || backoff || (hold_req && grant_ack)));

    // R1
    reset_out_chk: assert property (@(posedge clk)
        $past(rst) |-> (!grant_ack && line_hit_n && dirty_hit_n));

endmodule

// File: tb/test_snoop_inquire_ctrl.sv
module test_snoop_inquire_ctrl;

    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ah = 0, bo = 0, hr = 0, drv = 0, ostr = 0, istr = 0, wb = 0;
    logic ld = 0;
    logic [AW-1:0] iaddr = '0, laddr = '0;
    logic [1:0] lst = '0;
    logic grant_ack, line_hit_n, dirty_hit_n;

    int vectors = 0;
    int fails   = 0;

    // bench reference state
    logic m_grant, m_acc, m_os1, m_os2, m_hit_n, m_dirty_n;
    logic [1:0] m_own;
    logic [22:0] m_tag [16];
    logic [1:0]  m_st  [16];

    always #4 clk = ~clk;

    snoop_inquire_ctrl i_snoop_inquire_ctrl (
        .clk(clk), .rst(rst), .addr_hold(ah), .backoff(bo), .hold_req(hr),
        .own_bus_drive(drv), .own_strobe(ostr), .inq_strobe(istr),
        .inq_addr(iaddr), .wb_done(wb), .tload_en(ld), .tload_addr(laddr),
        .tload_state(lst), .grant_ack(grant_ack), .line_hit_n(line_hit_n),
        .dirty_hit_n(dirty_hit_n)
    );

    function automatic logic [AW-1:0] mk(input logic [22:0] t, input logic [3:0] i);
        return {t, i, 5'h0B};
    endfunction

    task automatic model_edge();
        logic own_now, seize, acc, hit, dty;
        logic [3:0] idx;
        if (rst) begin
            m_grant = 0; m_acc = 0; m_os1 = 0; m_os2 = 0; m_own = 0;
            m_hit_n = 1; m_dirty_n = 1;
            for (int i = 0; i < 16; i++) m_st[i] = 2'd0;
            return;
        end
        own_now = ah | bo | (hr & m_grant);
        seize   = ah | bo | (hr & ~drv);
        acc = (m_own == 2) && own_now && !m_acc && !m_os2 && !drv && m_dirty_n && istr;
        idx = iaddr[8:5];
        hit = (m_st[idx] != 0) && (m_tag[idx] == iaddr[31:9]);
        dty = hit && (m_st[idx] == 3);
        if (acc) begin
            m_hit_n = !hit; m_dirty_n = !dty;
        end else if (wb) m_dirty_n = 1;
        case (m_own)
            2'd0:    m_own = seize ? 2'd1 : 2'd0;
            default: m_own = own_now ? 2'd2 : 2'd0;
        endcase
        m_grant = hr & (m_grant | ~drv);
        m_os2 = m_os1; m_os1 = ostr; m_acc = acc;
        if (ld) begin
            m_tag[laddr[8:5]] = laddr[31:9];
            m_st[laddr[8:5]]  = lst;
        end
    endtask

    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        vectors++;
        if ({grant_ack, line_hit_n, dirty_hit_n} !== {m_grant, m_hit_n, m_dirty_n}) begin
            fails++;
            $display("FAIL %s grant/hit_n/dirty_n actual=%b%b%b expected=%b%b%b",
                     req, grant_ack, line_hit_n, dirty_hit_n, m_grant, m_hit_n, m_dirty_n);
        end
    endtask

    task automatic drive(input logic a, b, h, d, o, s, input logic [AW-1:0] ad, input logic w);
        ah = a; bo = b; hr = h; drv = d; ostr = o; istr = s; iaddr = ad; wb = w;
    endtask

    task automatic tload(input logic [AW-1:0] ad, input logic [1:0] s);
        ld = 1; laddr = ad; lst = s;
        step("R10");
        ld = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired: actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] a_mod, a_shr, a_exc, a_miss;
        void'($urandom(32'd1357));
        a_mod  = mk(23'h11, 4'd0);
        a_shr  = mk(23'h22, 4'd1);
        a_exc  = mk(23'h33, 4'd2);
        a_miss = mk(23'h44, 4'd2);
        @(negedge clk);
        step("R1"); step("R1");
        rst = 0;
        step("R1");
        // R1: table invalid after reset, lookup of the same address before loading
        drive(1,0,0,0,0,1,a_exc,0);
        step("R1"); step("R1"); step("R1"); step("R1");
        drive(0,0,0,0,0,0,a_exc,0);
        step("R1"); step("R1");
        tload(a_mod, 2'd3);
        tload(a_shr, 2'd1);
        tload(a_exc, 2'd2);
        // R11: no owner, strobe on a present line
        drive(0,0,0,0,0,1,a_exc,0);
        step("R11"); step("R11"); step("R11");
        // R2: address-hold path, two edges of settling
        drive(1,0,0,0,0,1,a_exc,0);
        step("R2"); step("R2"); step("R2");
        // R4: strobe on next edge ignored
        drive(1,0,0,0,0,1,a_miss,0);
        step("R4");
        step("R8");
        drive(1,0,0,0,1,0,a_exc,0);
        step("R5");
        drive(1,0,0,0,0,0,a_exc,0);
        step("R5");
        drive(1,0,0,0,0,1,a_exc,0);
        step("R5");
        drive(1,0,0,1,0,1,a_exc,0);
        step("R6");
        drive(1,0,0,0,0,1,a_mod,0);
        step("R8");
        drive(1,0,0,0,0,0,a_mod,0);
        step("R8");
        drive(1,0,0,0,0,1,a_miss,0);
        step("R7"); step("R7");
        drive(1,0,0,0,0,0,a_miss,1);
        step("R9");
        drive(1,0,0,0,0,1,a_miss,0);
        step("R8");
        drive(0,0,0,0,0,0,a_miss,0);
        step("R2"); step("R2");
        // R2: backoff path
        drive(0,1,0,0,0,1,a_shr,0);
        step("R2"); step("R2"); step("R2");
        drive(0,0,0,0,0,0,a_shr,0);
        step("R2");
        // R3: hold request held off by bus drive, then granted
        drive(0,0,1,1,0,1,a_mod,0);
        step("R3"); step("R3");
        drive(0,0,1,0,0,1,a_mod,0);
        step("R3"); step("R3"); step("R3");
        drive(0,0,1,0,0,0,a_mod,1);
        step("R9");
        drive(0,0,0,0,0,1,a_exc,0);
        step("R3"); step("R3");
        // random phase
        for (int n = 0; n < 6000; n++) begin
            logic [3:0] r;
            logic [AW-1:0] ra;
            r  = 4'($urandom);
            ra = mk(23'($urandom_range(0, 3)), 4'($urandom_range(0, 3)));
            ah  = ($urandom_range(0, 9) < 4) ? ah  ^ (r[0] & r[1]) : ah;
            bo  = (r == 4'd7) ? ~bo : bo;
            hr  = ($urandom_range(0, 15) == 0) ? ~hr : hr;
            drv = ($urandom_range(0, 9) == 0);
            ostr = ($urandom_range(0, 11) == 0);
            istr = ($urandom_range(0, 2) != 0);
            wb   = ($urandom_range(0, 7) == 0);
            iaddr = ra;
            ld = ($urandom_range(0, 19) == 0);
            laddr = mk(23'($urandom_range(0, 3)), 4'($urandom_range(0, 3)));
            lst = 2'($urandom);
            step(r[0] ? "R8" : "R4");
        end
        ld = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule